// File: doc/BRIEF.md
# DMA Register Bank and Interrupt Combiner

This block is the software-visible face of a multi-channel DMA engine. It decodes 32-bit word reads and writes inside a 4 KB address window, holds the global configuration and synchronisation words, and holds five words for each channel: source, destination, next-descriptor pointer, control and configuration. The channel engine is a separate block. It reads every stored value through flat output vectors. It reports finished transfers and faults through per-channel set pulses.

Each channel has one raw terminal-count bit and one raw error bit. The masks are not separate registers. Each channel's configuration word supplies them: bit 15 enables its terminal-count interrupt and bit 14 enables its error interrupt. Software can read status raw or masked and clears it by writing ones. A single registered level interrupt is high while any masked status bit is set. Offsets that match no register read as zero, leave all state unchanged, and raise a one-cycle decode-error pulse.

Top module: `dma_regbank`

## Requirements
- R1: After reset every stored word and every status bit is zero, `irq` is low and `dec_err` is low.
- R2: Channel c has its words at 0x100 + 0x20·c: source +0x00, destination +0x04, next pointer +0x08, control +0x0C, configuration +0x10. Each is written and read back whole and appears on the matching `ch_*` output slice [32c +: 32].
- R3: The global configuration word at 0x30 and the synchronisation word at 0x34 are read/write and drive `glb_cfg` and `glb_sync`.
- R4: A high bit on `tc_set` or `err_set` sets the matching raw bit at the next clock edge. Raw terminal-count status reads at 0x14 and raw error status reads at 0x18, with bit n standing for channel n.
- R5: Masked terminal-count status at 0x04 is raw TC AND cfg bit 15, per channel. Masked error status at 0x0C is raw error AND cfg bit 14. 0x00 returns the OR of the two.
- R6: Writing to 0x08 clears each raw TC bit whose data bit is 1, and writing to 0x10 does the same for raw error bits. Bits written as 0 keep their value. Both offsets read as zero.
- R7: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: `irq` is registered. It goes high one cycle after the combined masked status becomes nonzero and low one cycle after it becomes zero.
- R9: 0x1C returns a bitmap with bit n equal to bit 0 of channel n's configuration word.
- R10: The words at 0xFE0 to 0xFFC return 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1 in address order. The first byte is 0x81 when NCH is 2.
- R11: The soft request words at 0x20 to 0x2C read as zero, ignore writes and raise no decode error.
- R12: Any other offset reads as zero and changes no state. This covers a channel index at or above NCH, a channel word offset above +0x10, global words 0x38/0x3C and unmapped space. Such a read or write makes `dec_err` high for exactly the following cycle.
- R13: `dec_err` stays low after valid accesses and in cycles with no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address inside the window |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational while `bus_rd` is high, else zero |
| dec_err | output | 1 | One-cycle pulse after an access to an unmapped offset |
| tc_set | input | NCH | Engine terminal-count set pulses, one per channel |
| err_set | input | NCH | Engine error set pulses, one per channel |
| ch_src | output | NCH·DW | Source words of all channels |
| ch_dst | output | NCH·DW | Destination words of all channels |
| ch_next | output | NCH·DW | Next-descriptor words of all channels |
| ch_ctrl | output | NCH·DW | Control words of all channels |
| ch_cfg | output | NCH·DW | Configuration words of all channels |
| glb_cfg | output | DW | Global configuration word |
| glb_sync | output | DW | Synchronisation word |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds two copies that share one bus: one with NCH = 8 and one with NCH = 2. The eight-channel copy covers every channel slot, so it exercises the full status bitmaps, mask derivation and the interrupt path. The two-channel copy receives the same writes to channels 2 to 7 and must flag them as decode errors while it keeps its own state. It also returns the alternate first identification byte. Together the two copies test index-range checking against a channel count that does not fill the address field.

// File: rtl/dma_regbank.sv
module dma_regbank #(
  parameter int NCH = 8,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              dec_err,
  input  logic [NCH-1:0]    tc_set,
  input  logic [NCH-1:0]    err_set,
  output logic [NCH*DW-1:0] ch_src,
  output logic [NCH*DW-1:0] ch_dst,
  output logic [NCH*DW-1:0] ch_next,
  output logic [NCH*DW-1:0] ch_ctrl,
  output logic [NCH*DW-1:0] ch_cfg,
  output logic [DW-1:0]     glb_cfg,
  output logic [DW-1:0]     glb_sync,
  output logic              irq
);
  localparam int TC_EN_BIT  = 15;
  localparam int ERR_EN_BIT = 14;
  localparam int PAD        = DW - NCH;
  localparam logic [7:0] ID0 = (NCH == 2) ? 8'h81 : 8'h80;

  logic [DW-1:0] src_q  [NCH];
  logic [DW-1:0] dst_q  [NCH];
  logic [DW-1:0] nxt_q  [NCH];
  logic [DW-1:0] ctl_q  [NCH];
  logic [DW-1:0] cfg_q  [NCH];
  logic [DW-1:0] gcfg_q, gsync_q;
  logic [NCH-1:0] raw_tc, raw_err, tc_mask, err_mask, chan_en;

  logic [3:0] widx;
  logic [2:0] chan_idx, reg_sel, id_idx;
  logic glb_hit, glb_ok, ch_hit, ch_ok, id_hit, valid, acc;

  assign widx     = bus_addr[5:2];
  assign chan_idx = bus_addr[7:5];
  assign reg_sel  = bus_addr[4:2];
  assign id_idx   = bus_addr[4:2];

  assign glb_hit = (bus_addr[AW-1:6] == '0);
  assign glb_ok  = glb_hit && (widx <= 4'd13);
  assign ch_hit  = (bus_addr[AW-1:8] == (AW-8)'(1));
  assign ch_ok   = ch_hit && (reg_sel <= 3'd4) && ({1'b0, chan_idx} < 4'(NCH));
  assign id_hit  = &bus_addr[AW-1:5];
  assign valid   = glb_ok || ch_ok || id_hit;
  assign acc     = bus_wr || bus_rd;

  logic wr_glb;
  assign wr_glb = bus_wr && glb_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcfg_q  <= '0;
      gsync_q <= '0;
    end else if (wr_glb) begin
      if (widx == 4'd12) gcfg_q  <= bus_wdata;
      if (widx == 4'd13) gsync_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        src_q[c] <= '0;
        dst_q[c] <= '0;
        nxt_q[c] <= '0;
        ctl_q[c] <= '0;
        cfg_q[c] <= '0;
      end
    end else if (bus_wr && ch_ok) begin
      for (int c = 0; c < NCH; c++) begin
        if (chan_idx == 3'(c)) begin
          case (reg_sel)
            3'd0:    src_q[c] <= bus_wdata;
            3'd1:    dst_q[c] <= bus_wdata;
            3'd2:    nxt_q[c] <= bus_wdata;
            3'd3:    ctl_q[c] <= bus_wdata;
            default: cfg_q[c] <= bus_wdata;
          endcase
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign tc_mask[g]  = cfg_q[g][TC_EN_BIT];
      assign err_mask[g] = cfg_q[g][ERR_EN_BIT];
      assign chan_en[g]  = cfg_q[g][0];
      assign ch_src [g*DW +: DW] = src_q[g];
      assign ch_dst [g*DW +: DW] = dst_q[g];
      assign ch_next[g*DW +: DW] = nxt_q[g];
      assign ch_ctrl[g*DW +: DW] = ctl_q[g];
      assign ch_cfg [g*DW +: DW] = cfg_q[g];
    end
  endgenerate

  assign glb_cfg  = gcfg_q;
  assign glb_sync = gsync_q;

  logic [NCH-1:0] tc_clr, err_clr, tc_masked, err_masked;
  assign tc_clr     = (wr_glb && widx == 4'd2) ? bus_wdata[NCH-1:0] : '0;
  assign err_clr    = (wr_glb && widx == 4'd4) ? bus_wdata[NCH-1:0] : '0;
  assign tc_masked  = raw_tc & tc_mask;
  assign err_masked = raw_err & err_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_tc  <= '0;
      raw_err <= '0;
      irq     <= 1'b0;
      dec_err <= 1'b0;
    end else begin
      raw_tc  <= (raw_tc & ~tc_clr) | tc_set;
      raw_err <= (raw_err & ~err_clr) | err_set;
      irq     <= |(tc_masked | err_masked);
      dec_err <= acc && !valid;
    end
  end

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0: id_byte = ID0;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h0A;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  logic [DW-1:0] glb_rd, ch_rd;

  always_comb begin
    case (widx)
      4'd0:  glb_rd = {{PAD{1'b0}}, tc_masked | err_masked};
      4'd1:  glb_rd = {{PAD{1'b0}}, tc_masked};
      4'd3:  glb_rd = {{PAD{1'b0}}, err_masked};
      4'd5:  glb_rd = {{PAD{1'b0}}, raw_tc};
      4'd6:  glb_rd = {{PAD{1'b0}}, raw_err};
      4'd7:  glb_rd = {{PAD{1'b0}}, chan_en};
      4'd12: glb_rd = gcfg_q;
      4'd13: glb_rd = gsync_q;
      default: glb_rd = '0;
    endcase
  end

  always_comb begin
    ch_rd = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chan_idx == 3'(c)) begin
        case (reg_sel)
          3'd0:    ch_rd = src_q[c];
          3'd1:    ch_rd = dst_q[c];
          3'd2:    ch_rd = nxt_q[c];
          3'd3:    ch_rd = ctl_q[c];
          default: ch_rd = cfg_q[c];
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (glb_ok)      bus_rdata = glb_rd;
      else if (ch_ok)  bus_rdata = ch_rd;
      else if (id_hit) bus_rdata = {{(DW-8){1'b0}}, id_byte(id_idx)};
    end
  end
endmodule

// File: rtl/dma_regbank_chk.sv
module dma_regbank_chk #(
  parameter int NCH = 8,
  parameter int AW  = 12,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic [NCH-1:0] tc_set,
  input logic [NCH-1:0] err_set,
  input logic [NCH-1:0] raw_tc,
  input logic [NCH-1:0] raw_err,
  input logic [NCH-1:0] tc_mask,
  input logic [NCH-1:0] err_mask,
  input logic           dec_err,
  input logic           irq
);
  logic any_pending;
  assign any_pending = |((raw_tc & tc_mask) | (raw_err & err_mask));

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_pending |=> irq);
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pending |=> !irq);
  p_tc_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != '0) |=> ((raw_tc & $past(tc_set)) == $past(tc_set)));
  p_err_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (err_set != '0) |=> ((raw_err & $past(err_set)) == $past(err_set)));
  p_tc_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(12'h008)) |=>
      ((raw_tc & $past(bus_wdata[NCH-1:0] & ~tc_set)) == '0));
  p_tc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set == '0 && !bus_wr) |=> $stable(raw_tc));
  p_idle_noerr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr || bus_rd) |=> !dec_err);
  p_hole_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(12'h038)) |=> dec_err);
endmodule

bind dma_regbank dma_regbank_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .tc_set(tc_set),
  .err_set(err_set), .raw_tc(raw_tc), .raw_err(raw_err),
  .tc_mask(tc_mask), .err_mask(err_mask), .dec_err(dec_err), .irq(irq)
);

// File: tb/sim_dma_regbank.sv
module sim_dma_regbank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [7:0] tc_set0 = '0, err_set0 = '0;
  logic [1:0] tc_set1 = '0, err_set1 = '0;
  logic [31:0] rdata0, rdata1, gcfg0, gsync0, gcfg1, gsync1;
  logic err0, err1, irq0, irq1;
  logic [255:0] src0, dst0, nxt0, ctl0, cfg0;
  logic [63:0] src1, dst1, nxt1, ctl1, cfg1;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_regbank #(.NCH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata0), .dec_err(err0), .tc_set(tc_set0),
    .err_set(err_set0), .ch_src(src0), .ch_dst(dst0), .ch_next(nxt0), .ch_ctrl(ctl0),
    .ch_cfg(cfg0), .glb_cfg(gcfg0), .glb_sync(gsync0), .irq(irq0));

  dma_regbank #(.NCH(2)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .dec_err(err1), .tc_set(tc_set1),
    .err_set(err_set1), .ch_src(src1), .ch_dst(dst1), .ch_next(nxt1), .ch_ctrl(ctl1),
    .ch_cfg(cfg1), .glb_cfg(gcfg1), .glb_sync(gsync1), .irq(irq1));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic e0, output logic e1);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    e0 = err0; e1 = err1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d0, output logic [31:0] d1,
                    output logic e0, output logic e1);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2; d0 = rdata0; d1 = rdata1;
    @(posedge clk); #2;
    e0 = err0; e1 = err1;
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] t, input logic [7:0] e);
    @(negedge clk);
    tc_set0 = t; err_set0 = e;
    @(negedge clk);
    tc_set0 = '0; err_set0 = '0;
  endtask

  task automatic wipe();
    logic a, b;
    for (int c = 0; c < 8; c++) wr(12'h110 + 12'(c * 32), 32'h0, a, b);
    wr(12'h008, 32'hFF, a, b);
    wr(12'h010, 32'hFF, a, b);
  endtask

  task automatic t_reset();
    logic [31:0] d0, d1; logic e0, e1;
    check("R1 irq", {31'b0, irq0}, 32'h0);
    check("R1 dec_err", {31'b0, err0}, 32'h0);
    rd(12'h000, d0, d1, e0, e1); check("R1 combined", d0, 32'h0);
    rd(12'h014, d0, d1, e0, e1); check("R1 raw tc", d0, 32'h0);
    rd(12'h01C, d0, d1, e0, e1); check("R1 enabled", d0, 32'h0);
    rd(12'h130, d0, d1, e0, e1); check("R1 ch1 cfg", d0, 32'h0);
    check("R13 no err on valid read", {31'b0, e0}, 32'h0);
  endtask

  task automatic t_chan_regs();
    logic [31:0] d0, d1; logic e0, e1;
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 5; r++) begin
        wr(12'h100 + 12'(c * 32 + r * 4), 32'hC0DE_0000 | 32'(c << 8) | 32'(r), e0, e1);
        if (c >= 2) check("R12 u1 write beyond NCH flags", {31'b0, e1}, 32'h1);
      end
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 5; r++) begin
        rd(12'h100 + 12'(c * 32 + r * 4), d0, d1, e0, e1);
        check("R2 readback", d0, 32'hC0DE_0000 | 32'(c << 8) | 32'(r));
        if (c >= 2) check("R12 u1 read beyond NCH is zero", d1, 32'h0);
      end
    check("R2 ch3 src out", src0[3*32 +: 32], 32'hC0DE_0300);
    check("R2 ch7 dst out", dst0[7*32 +: 32], 32'hC0DE_0701);
    check("R2 ch5 next out", nxt0[5*32 +: 32], 32'hC0DE_0502);
    check("R2 ch6 ctrl out", ctl0[6*32 +: 32], 32'hC0DE_0603);
    check("R2 ch2 cfg out", cfg0[2*32 +: 32], 32'hC0DE_0204);
    check("R12 u1 ch1 kept", src1[32 +: 32], 32'hC0DE_0100);
  endtask

  task automatic t_global();
    logic [31:0] d0, d1; logic e0, e1;
    wr(12'h030, 32'h0000_0001, e0, e1);
    wr(12'h034, 32'h0000_FFFF, e0, e1);
    rd(12'h030, d0, d1, e0, e1); check("R3 cfg read", d0, 32'h1);
    rd(12'h034, d0, d1, e0, e1); check("R3 sync read", d0, 32'hFFFF);
    check("R3 glb_cfg out", gcfg0, 32'h1);
    check("R3 glb_sync out", gsync0, 32'hFFFF);
  endtask

  task automatic t_status();
    logic [31:0] d0, d1; logic e0, e1;
    wipe();
    pulse(8'h05, 8'h00);
    rd(12'h014, d0, d1, e0, e1); check("R4 raw tc", d0, 32'h05);
    rd(12'h004, d0, d1, e0, e1); check("R5 tc masked off", d0, 32'h0);
    wr(12'h110, 32'h0000_8000, e0, e1);
    rd(12'h004, d0, d1, e0, e1); check("R5 tc masked ch0", d0, 32'h01);
    pulse(8'h00, 8'h30);
    rd(12'h018, d0, d1, e0, e1); check("R4 raw err", d0, 32'h30);
    rd(12'h00C, d0, d1, e0, e1); check("R5 err masked off", d0, 32'h0);
    wr(12'h1B0, 32'h0000_4000, e0, e1);
    rd(12'h00C, d0, d1, e0, e1); check("R5 err masked ch5", d0, 32'h20);
    rd(12'h000, d0, d1, e0, e1); check("R5 combined", d0, 32'h21);
  endtask

  task automatic t_irq();
    logic [31:0] d0, d1; logic e0, e1;
    wipe();
    @(posedge clk); #2; check("R8 irq low after wipe", {31'b0, irq0}, 32'h0);
    pulse(8'h00, 8'h08);
    @(posedge clk); #2; check("R8 unmasked err no irq", {31'b0, irq0}, 32'h0);
    wr(12'h170, 32'h0000_4000, e0, e1);
    check("R8 irq not yet", {31'b0, irq0}, 32'h0);
    @(posedge clk); #2; check("R8 irq rises one cycle later", {31'b0, irq0}, 32'h1);
    wr(12'h010, 32'h0000_0008, e0, e1);
    check("R8 irq still high", {31'b0, irq0}, 32'h1);
    @(posedge clk); #2; check("R8 irq falls one cycle later", {31'b0, irq0}, 32'h0);
    rd(12'h018, d0, d1, e0, e1); check("R6 err cleared", d0, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] d0, d1; logic e0, e1;
    wipe();
    pulse(8'h0C, 8'h81);
    wr(12'h008, 32'h0000_0004, e0, e1);
    rd(12'h014, d0, d1, e0, e1); check("R6 partial tc clear", d0, 32'h08);
    wr(12'h010, 32'h0000_0080, e0, e1);
    rd(12'h018, d0, d1, e0, e1); check("R6 partial err clear", d0, 32'h01);
    rd(12'h008, d0, d1, e0, e1); check("R6 clear reg reads zero", d0, 32'h0);
    pulse(8'h10, 8'h00);
    @(negedge clk);
    tc_set0 = 8'h02; bus_wr = 1'b1; bus_addr = 12'h008; bus_wdata = 32'hFF;
    @(posedge clk); #2;
    tc_set0 = '0; bus_wr = 1'b0;
    rd(12'h014, d0, d1, e0, e1); check("R7 set beats clear", d0, 32'h02);
  endtask

  task automatic t_enabled();
    logic [31:0] d0, d1; logic e0, e1;
    wipe();
    wr(12'h130, 32'h0000_0001, e0, e1);
    wr(12'h1D0, 32'h0000_C001, e0, e1);
    rd(12'h01C, d0, d1, e0, e1); check("R9 enabled bitmap", d0, 32'h42);
    check("R9 u1 bitmap", d1, 32'h2);
  endtask

  task automatic t_id();
    logic [31:0] d0, d1; logic e0, e1;
    logic [7:0] exp [8] = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), d0, d1, e0, e1);
      check("R10 id byte", d0, {24'h0, exp[i]});
      check("R10 id byte 2ch", d1, {24'h0, (i == 0) ? 8'h81 : exp[i]});
    end
  endtask

  task automatic t_soft();
    logic [31:0] d0, d1; logic e0, e1;
    for (int i = 0; i < 4; i++) begin
      wr(12'h020 + 12'(i * 4), 32'hFFFF_FFFF, e0, e1);
      check("R11 no err on soft write", {31'b0, e0}, 32'h0);
      rd(12'h020 + 12'(i * 4), d0, d1, e0, e1);
      check("R11 soft reads zero", d0, 32'h0);
    end
    rd(12'h030, d0, d1, e0, e1); check("R11 global cfg untouched", d0, 32'h1);
    rd(12'h01C, d0, d1, e0, e1); check("R11 bitmap untouched", d0, 32'h42);
  endtask

  task automatic t_invalid();
    logic [31:0] d0, d1; logic e0, e1;
    rd(12'h038, d0, d1, e0, e1);
    check("R12 hole reads zero", d0, 32'h0);
    check("R12 dec_err pulse", {31'b0, e0}, 32'h1);
    @(posedge clk); #2; check("R12 pulse one cycle", {31'b0, err0}, 32'h0);
    wr(12'h114, 32'hDEAD_BEEF, e0, e1);
    check("R12 bad ch word flags", {31'b0, e0}, 32'h1);
    wr(12'h03C, 32'hDEAD_BEEF, e0, e1);
    wr(12'h200, 32'hDEAD_BEEF, e0, e1);
    check("R12 unmapped flags", {31'b0, e0}, 32'h1);
    rd(12'h100, d0, d1, e0, e1); check("R12 ch0 src kept", d0, 32'hC0DE_0000);
    rd(12'h034, d0, d1, e0, e1); check("R12 sync kept", d0, 32'hFFFF);
    check("R13 valid read no err", {31'b0, e0}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_chan_regs();
    t_global();
    t_status();
    t_irq();
    t_clear();
    t_enabled();
    t_id();
    t_soft();
    t_invalid();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule